// File: doc/BRIEF.md
# Control-Flow Next-PC Unit

This unit owns the program counter of a small 16-bit register machine and works out where execution goes after each fetched word. It handles three kinds of control transfer. A conditional branch is PC-relative and qualified by a three-bit flag mask. A jump loads its target from a general register. A service call fetches its target through a 256-entry vector table in memory and leaves a return address in a link register. Every other opcode simply advances the PC by one.

The surrounding pipeline presents one instruction together with `issue`, the stored negative/zero/positive flags, and the value on a register-file read port addressed by the unit. Branches, jumps and plain instructions complete at the next clock edge. A service call takes at least two edges. The first accepts it and writes the link. The unit then holds a memory read request until the memory answers. `done` marks the cycle in which `pc` first shows the new value.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` becomes 16'h3000 and `done`, `mem_req` and `lnk_we` become 0.
- R2: A branch has opcode 4'b0000 in bits [15:12], with flag-mask bits n=[11], z=[10] and p=[9], and a 9-bit two's-complement offset in [8:0]. It is taken when any mask bit matches a set input flag. A taken branch makes `pc` equal to PC+1 plus the sign-extended offset.
- R3: A branch whose mask matches no set flag, including the all-zero mask, makes `pc` equal to PC+1.
- R4: A branch with all three mask bits set is taken whatever the flags are, even when all three flags are 0.
- R5: The branch offset reaches from -256 (field 9'h100) to +255 (field 9'h0FF) relative to PC+1. All PC arithmetic wraps modulo 2^16.
- R6: A jump (opcode 4'b1100) drives `rf_addr` with instruction bits [8:6] during the issue cycle. It makes `pc` equal to `rf_data` as sampled at that edge, unconditionally.
- R7: A service call (opcode 4'b1111) takes its vector from bits [7:0]. In the cycle after acceptance, `lnk_we` pulses for one cycle with `lnk_addr`=7 and `lnk_data`=PC+1. From that cycle, `mem_req` stays high with `mem_addr` equal to the zero-extended vector until `mem_rvalid` is seen. At that edge `pc` takes `mem_rdata`.
- R8: Any other opcode makes `pc` equal to PC+1, with no link write and no memory request.
- R9: While a service call waits for memory, `issue` is ignored and `pc` does not change.
- R10: Each accepted instruction produces exactly one single-cycle `done` pulse. `pc` changes only in a cycle in which `done` is high, and it shows the new value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction presented for next-PC evaluation |
| instr | input | 16 | Fetched instruction word |
| flag_n | input | 1 | Stored negative flag |
| flag_z | input | 1 | Stored zero flag |
| flag_p | input | 1 | Stored positive flag |
| rf_addr | output | 3 | Register-file read address (jump base) |
| rf_data | input | 16 | Register-file read data |
| mem_req | output | 1 | Vector-table read request |
| mem_addr | output | 16 | Vector-table read address |
| mem_rvalid | input | 1 | Vector-table read data valid |
| mem_rdata | input | 16 | Vector-table read data |
| pc | output | 16 | Program counter |
| done | output | 1 | New PC valid this cycle |
| lnk_we | output | 1 | Link register write strobe |
| lnk_addr | output | 3 | Link register index |
| lnk_data | output | 16 | Return address |

## Verification
A wrong sequencing state shows up at once on the ports. A service-call wait state that is lost drops `mem_req` before the answer arrives and leaves `done` missing for the scoreboard. A wait state that gets stuck keeps `mem_req` high after `done`. A stale or wrongly extended vector register shows as a wrong `mem_addr` one cycle after acceptance. An error in the flag match or in offset extension gives a wrong `pc` on the very `done` cycle of that branch, and every later expected PC then also fails. The bench therefore checks each target against a PC that it tracks itself, and it probes the offset range limits, the always-taken mask with all flags clear, wraparound, and variable memory latency.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN   = 16;
    localparam int RIDX_W = 3;
    localparam int VEC_W  = 8;
    localparam int OFF_W  = 9;

    localparam logic [3:0] OPC_BRANCH = 4'b0000;
    localparam logic [3:0] OPC_JUMP   = 4'b1100;
    localparam logic [3:0] OPC_SVC    = 4'b1111;

    typedef enum logic [1:0] {
        K_SEQ,
        K_BRANCH,
        K_JUMP,
        K_SVC
    } xfer_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } seq_state_e;

    typedef struct packed {
        xfer_kind_e             kind;
        logic                   take;
        logic [RIDX_W-1:0]      base;
        logic [VEC_W-1:0]       vec;
        logic [XLEN-1:0]        offs;
    } xfer_dec_t;

    function automatic logic [XLEN-1:0] sext_off(input logic [OFF_W-1:0] f);
        return {{(XLEN-OFF_W){f[OFF_W-1]}}, f};
    endfunction

    function automatic logic [XLEN-1:0] zext_vec(input logic [VEC_W-1:0] v);
        return {{(XLEN-VEC_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    input  logic [2:0]      flags,
    output xfer_dec_t       dec
);
    logic [3:0] opc;
    logic [2:0] mask;

    always_comb begin
        opc        = instr[XLEN-1 -: 4];
        mask       = instr[11:9];
        dec.base   = instr[8:6];
        dec.vec    = instr[VEC_W-1:0];
        dec.offs   = sext_off(instr[OFF_W-1:0]);
        dec.take   = (mask == 3'b111) || ((mask & flags) != 3'b000);
        unique case (opc)
            OPC_BRANCH: dec.kind = K_BRANCH;
            OPC_JUMP:   dec.kind = K_JUMP;
            OPC_SVC:    dec.kind = K_SVC;
            default:    dec.kind = K_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] cur_pc,
    input  xfer_kind_e      kind,
    input  logic            take,
    input  logic [XLEN-1:0] offs,
    input  logic [XLEN-1:0] base_val,
    output logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] tgt_pc
);
    always_comb begin
        seq_pc = cur_pc + XLEN'(1);
        unique case (kind)
            K_BRANCH: tgt_pc = take ? (seq_pc + offs) : seq_pc;
            K_JUMP:   tgt_pc = base_val;
            default:  tgt_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/npc_seq.sv
module npc_seq
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = 16'h3000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  xfer_kind_e       kind,
    input  logic [VEC_W-1:0] vec,
    input  logic [XLEN-1:0]  seq_pc,
    input  logic [XLEN-1:0]  tgt_pc,
    input  logic             mem_rvalid,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic [XLEN-1:0]  pc_q,
    output logic             done_q,
    output logic             mem_req,
    output logic [XLEN-1:0]  mem_addr,
    output logic             lnk_we_q,
    output logic [XLEN-1:0]  lnk_data_q
);
    seq_state_e       st;
    logic [VEC_W-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            pc_q       <= RESET_PC;
            done_q     <= 1'b0;
            lnk_we_q   <= 1'b0;
            lnk_data_q <= '0;
            vec_q      <= '0;
        end else begin
            done_q   <= 1'b0;
            lnk_we_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (issue) begin
                        if (kind == K_SVC) begin
                            st         <= ST_WAIT;
                            vec_q      <= vec;
                            lnk_we_q   <= 1'b1;
                            lnk_data_q <= seq_pc;
                        end else begin
                            pc_q   <= tgt_pc;
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        pc_q   <= mem_rdata;
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_req  = (st == ST_WAIT);
    assign mem_addr = zext_vec(vec_q);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0]   RESET_PC = 16'h3000,
    parameter logic [RIDX_W-1:0] LINK_REG = 3'd7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [XLEN-1:0]   instr,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_p,
    output logic [RIDX_W-1:0] rf_addr,
    input  logic [XLEN-1:0]   rf_data,
    output logic              mem_req,
    output logic [XLEN-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic [XLEN-1:0]   pc,
    output logic              done,
    output logic              lnk_we,
    output logic [RIDX_W-1:0] lnk_addr,
    output logic [XLEN-1:0]   lnk_data
);
    xfer_dec_t       dec;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] tgt_pc;

    npc_decode u_dec (
        .instr (instr),
        .flags ({flag_n, flag_z, flag_p}),
        .dec   (dec)
    );

    npc_target u_tgt (
        .cur_pc   (pc),
        .kind     (dec.kind),
        .take     (dec.take),
        .offs     (dec.offs),
        .base_val (rf_data),
        .seq_pc   (seq_pc),
        .tgt_pc   (tgt_pc)
    );

    npc_seq #(.RESET_PC(RESET_PC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .issue      (issue),
        .kind       (dec.kind),
        .vec        (dec.vec),
        .seq_pc     (seq_pc),
        .tgt_pc     (tgt_pc),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .pc_q       (pc),
        .done_q     (done),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .lnk_we_q   (lnk_we),
        .lnk_data_q (lnk_data)
    );

    assign rf_addr  = dec.base;
    assign lnk_addr = LINK_REG;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
    import npc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   pc,
    input logic              done,
    input logic              mem_req,
    input logic [XLEN-1:0]   mem_addr,
    input logic              mem_rvalid,
    input logic              lnk_we,
    input logic [RIDX_W-1:0] lnk_addr
);
    // R7: request held with a stable address until memory answers
    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R7: link write lasts exactly one cycle
    p_link_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        lnk_we |=> !lnk_we);

    // R7: link always targets register 7
    p_link_reg_r7: assert property (@(posedge clk) disable iff (rst)
        lnk_we |-> (lnk_addr == 3'd7));

    // R7: a new request starts together with the link write
    p_req_with_link_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> lnk_we);

    // R9: no completion while still waiting for memory
    p_no_done_waiting_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> !done);

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: pc moves only when done is shown
    p_pc_moves_on_done_r10: assert property (@(posedge clk) disable iff (rst)
        (pc != $past(pc)) |-> done);
endmodule

bind npc_unit npc_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc         (pc),
    .done       (done),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .lnk_we     (lnk_we),
    .lnk_addr   (lnk_addr)
);

// File: tb/npc_unit_test.sv
module npc_unit_test;

    typedef struct {
        logic [15:0] pc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [15:0] instr = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_p = 1'b0;
    logic [2:0]  rf_addr;
    logic [15:0] rf_data = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] pc;
    logic        done;
    logic        lnk_we;
    logic [2:0]  lnk_addr;
    logic [15:0] lnk_data;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   ended  = 1'b0;
    exp_t sb[$];
    logic [15:0] m_pc;

    always #5 clk = ~clk;

    npc_unit uut (
        .clk(clk), .rst(rst), .issue(issue), .instr(instr),
        .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p),
        .rf_addr(rf_addr), .rf_data(rf_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .pc(pc), .done(done),
        .lnk_we(lnk_we), .lnk_addr(lnk_addr), .lnk_data(lnk_data)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pop one expectation per done pulse
    always @(negedge clk) begin
        if (!rst && done && !ended) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected done", pc, 16'hxxxx);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(pc == e.pc, e.tag, pc, e.pc);
            end
        end
    end

    // non-service instruction: completes one edge after issue
    task automatic drive(input logic [15:0] ins, input logic [2:0] fl, input logic [15:0] rfd,
                         input int rf_exp, input logic [15:0] exp_pc, input string tag);
        exp_t e;
        @(negedge clk);
        instr = ins; {flag_n, flag_z, flag_p} = fl; rf_data = rfd; issue = 1'b1;
        e.pc = exp_pc; e.tag = tag;
        sb.push_back(e);
        #1;
        if (rf_exp >= 0) check(rf_addr == 3'(rf_exp), "R6 rf_addr", 16'(rf_addr), 16'(rf_exp));
        @(negedge clk);
        issue = 1'b0;
        check(done == 1'b1, {tag, " done"}, 16'(done), 16'd1);
        check(!lnk_we && !mem_req, "R8 no link/no request", {14'd0, lnk_we, mem_req}, 16'd0);
        m_pc = exp_pc;
    endtask

    // service call with memory latency lat
    task automatic svc(input logic [7:0] vec, input int lat, input logic [15:0] tgt, input bit poke);
        exp_t e;
        logic [15:0] held;
        @(negedge clk);
        instr = {8'hF0, vec}; issue = 1'b1;
        e.pc = tgt; e.tag = "R7 vector target";
        sb.push_back(e);
        @(negedge clk);
        issue = 1'b0;
        held = pc;
        check(lnk_we && lnk_addr == 3'd7, "R7 link strobe", {12'd0, lnk_we, lnk_addr}, 16'h000F);
        check(lnk_data == m_pc + 16'd1, "R7 link data", lnk_data, m_pc + 16'd1);
        check(mem_req && mem_addr == {8'h00, vec}, "R7 request addr", mem_addr, {8'h00, vec});
        for (int i = 0; i < lat; i++) begin
            if (poke && i == 0) begin
                instr = 16'hC0C0; rf_data = 16'hBEEF; issue = 1'b1;
            end
            @(negedge clk);
            issue = 1'b0;
            check(mem_req == 1'b1 && !lnk_we, "R7 request held", {15'd0, mem_req}, 16'd1);
            check(pc == held && !done, "R9 pc frozen while waiting", pc, held);
        end
        mem_rvalid = 1'b1; mem_rdata = tgt;
        @(negedge clk);
        mem_rvalid = 1'b0;
        check(done == 1'b1 && !mem_req, "R7 complete", {14'd0, done, mem_req}, 16'h0002);
        m_pc = tgt;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pc == 16'h3000 && !done && !mem_req && !lnk_we, "R1 reset state", pc, 16'h3000);
        rst = 1'b0;
        m_pc = 16'h3000;

        // R2: mask n, flag n, offset +5
        drive(16'h0805, 3'b100, 16'h0, -1, m_pc + 16'd6, "R2 taken fwd");
        // R3: mask z, flag p
        drive(16'h0405, 3'b001, 16'h0, -1, m_pc + 16'd1, "R3 not taken");
        // R2: mask p, flag p, offset -3
        drive(16'h03FD, 3'b001, 16'h0, -1, m_pc - 16'd2, "R2 taken back");
        // R4: mask nzp, no flags, offset +16
        drive(16'h0E10, 3'b000, 16'h0, -1, m_pc + 16'd17, "R4 always taken");
        // R3: empty mask, flag z
        drive(16'h0010, 3'b010, 16'h0, -1, m_pc + 16'd1, "R3 empty mask");
        // R5: offset +255
        drive(16'h0CFF, 3'b010, 16'h0, -1, m_pc + 16'd256, "R5 max forward");
        // R5: offset -256
        drive(16'h0F00, 3'b100, 16'h0, -1, m_pc - 16'd255, "R5 max backward");
        // R6: jump via R3
        drive(16'hC0C0, 3'b010, 16'h4000, 3, 16'h4000, "R6 jump R3");
        // R6: jump via R7, flags irrelevant
        drive(16'hC1C0, 3'b000, 16'hFFFF, 7, 16'hFFFF, "R6 jump R7");
        // R8 / R5: other opcode, wraps to zero
        drive(16'h1234, 3'b001, 16'h0, -1, 16'h0000, "R8 sequential wrap");
        // R7: service call, zero latency
        svc(8'h25, 0, 16'h0520, 1'b0);
        // R9: service call with jump issued while waiting
        svc(8'h23, 3, 16'h0400, 1'b1);
        // R7: vector FF, zero extended
        svc(8'hFF, 1, 16'h1000, 1'b0);
        // R8: load-type opcode
        drive(16'h2000, 3'b111, 16'h0, -1, m_pc + 16'd1, "R8 other opcode");

        repeat (3) @(negedge clk);
        check(sb.size() == 0 && pc == m_pc, "R10 one done per instruction", pc, m_pc);

        ended = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule